// File: doc/BRIEF.md
# Serial Pixel Frame Deserializer

This block takes a single serial data line, sampled by a bit-rate clock that runs at the line rate, and turns it into a 27-bit parallel pixel word. The word holds 24 colour bits and 3 control bits; control bit 0 is the data-enable flag. The block also puts out a regenerated pixel clock that runs at one thirtieth of the bit clock. A frame is 30 bits long. It carries the 27 payload bits, an even parity bit and two framing bits.

After reset or after the incoming clock comes back, the receiver hunts for frame alignment one bit position at a time. It declares lock once the framing pattern has appeared on several frames in a row. While locked, it checks the parity of each frame. A frame that passes loads the output word on the rising edge of the regenerated pixel clock. A frame that fails is dropped, and the previous word stays on the outputs for one more pixel period. A clock-present input, driven by external clock-detect logic, forces a fixed idle pattern on the outputs and clears the alignment.

Top module: `srp_deser`

## Requirements
- R1: A frame is 30 bits in line order. Bit 0 is a start bit of 1. Bits 1..27 are the payload, least significant bit first: payload bits 0..23 become pixel bits 0..23 and payload bits 24..26 become control bits 0..2. Bit 28 is the parity bit, chosen so that the XOR of the payload and the parity bit is 0. Bit 29 is a stop bit of 0.
- R2: Lock is declared at the end of the third consecutive frame whose window shows start=1 and stop=0 at the same alignment. If that third frame has good parity, its payload is on the outputs from that same edge onward.
- R3: The alignment is found whatever the bit offset at which the first frame starts after reset or after the clock returns.
- R4: While locked, a frame that has correct framing but wrong parity leaves the pixel and control outputs unchanged, and lock is kept.
- R5: While locked, the pixel clock is high for the first 15 bit clocks of each frame period and low for the last 15. The outputs change only at its rising edge and stay stable through the whole period.
- R6: While clock-present is low, the outputs are idle. The pixel clock, data enable and lock are 0. All 24 pixel bits and control bits 1 and 2 are 1.
- R7: When clock-present returns, the outputs stay idle and unlocked until the alignment has been found again from scratch.
- R8: After reset the outputs show the idle pattern, with the pixel clock low and lock low.
- R9: While locked, a frame that fails the framing check drops lock and stops the pixel clock at 0. The outputs keep the last good word, and hunting resumes from the next bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bit_clk | input | 1 | Bit-rate clock, one rising edge per serial bit |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_present | input | 1 | High while the incoming clock is detected |
| sdata_in | input | 1 | Serial data line, sampled on the rising edge of bit_clk |
| pclk_out | output | 1 | Regenerated pixel clock |
| pix_out | output | 24 | Parallel pixel bits |
| ctl_out | output | 3 | Control bits; bit 0 is data enable |
| lock_out | output | 1 | High while frame alignment is held |

## Verification
The bench starts frames at random bit offsets, padded with zero training frames so that hunting cannot settle on a false alignment. A receiver that locked one frame early or late, or on the wrong bit, shows the wrong lock flag or the wrong word at the third frame boundary. Random payloads with injected parity faults catch a design that loads a bad word or drops lock on a parity error. A missing-start frame, a clock-loss window and a clock return catch outputs that do not hold the last good word, an idle pattern with the wrong bits, and a stale alignment that survives clock loss. At every bit of each locked frame the bench also checks the pixel clock duty cycle and confirms that the outputs stay stable.

// File: rtl/srp_pkg.sv
package srp_pkg;
  localparam int PIX_W      = 24;
  localparam int CTL_W      = 3;
  localparam int PAY_W      = PIX_W + CTL_W;
  localparam int FRAME_BITS = PAY_W + 3;
  localparam int PHASE_W    = $clog2(FRAME_BITS);
  localparam int HALF       = FRAME_BITS / 2;
  localparam int DE_IDX     = 0;
  localparam int PAR_IDX    = PAY_W + 1;
  localparam int STOP_IDX   = FRAME_BITS - 1;

  typedef logic [PAY_W-1:0]      payload_t;
  typedef logic [FRAME_BITS-1:0] frame_t;

  typedef struct packed {
    logic [CTL_W-1:0] ctl;
    logic [PIX_W-1:0] pix;
  } word_t;

  function automatic logic framing_ok(frame_t f);
    return f[0] && !f[STOP_IDX];
  endfunction

  function automatic payload_t frame_payload(frame_t f);
    return f[PAY_W:1];
  endfunction

  function automatic logic parity_ok(frame_t f);
    return ((^frame_payload(f)) ^ f[PAR_IDX]) == 1'b0;
  endfunction

  function automatic word_t idle_word();
    word_t w;
    w.pix = '1;
    w.ctl = '1;
    w.ctl[DE_IDX] = 1'b0;
    return w;
  endfunction

  function automatic word_t to_word(payload_t p);
    word_t w;
    w.pix = p[PIX_W-1:0];
    w.ctl = p[PAY_W-1:PIX_W];
    return w;
  endfunction
endpackage

// File: rtl/srp_shift_in.sv
module srp_shift_in
  import srp_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   clear,
  input  logic   sdata,
  output frame_t window
);
  frame_t sr_q;

  // Newest bit enters at the top, so after a full frame bit 0 holds the first bit sent.
  assign window = {sdata, sr_q[FRAME_BITS-1:1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sr_q <= '0;
    else if (clear) sr_q <= '0;
    else            sr_q <= window;
  end
endmodule

// File: rtl/srp_frame_check.sv
module srp_frame_check
  import srp_pkg::*;
(
  input  frame_t window,
  output logic   framed,
  output logic   par_good,
  output word_t  word
);
  assign framed   = framing_ok(window);
  assign par_good = parity_ok(window);
  assign word     = to_word(frame_payload(window));
endmodule

// File: rtl/srp_aligner.sv
module srp_aligner
  import srp_pkg::*;
#(
  parameter int LOCK_FRAMES = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clk_present,
  input  logic               framed,
  output logic               eval,
  output logic               accept,
  output logic               locked,
  output logic               lock_next,
  output logic [PHASE_W-1:0] phase_next
);
  localparam int CNT_W = $clog2(LOCK_FRAMES + 1);
  localparam logic [PHASE_W-1:0] LAST = PHASE_W'(FRAME_BITS - 1);

  logic [PHASE_W-1:0] phase_q;
  logic [CNT_W-1:0]   cnt_q, cnt_n;

  assign eval = (phase_q == LAST);

  always_comb begin
    phase_next = phase_q;
    cnt_n      = cnt_q;
    lock_next  = locked;
    if (!clk_present) begin
      phase_next = '0;
      cnt_n      = '0;
      lock_next  = 1'b0;
    end else if (!eval) begin
      phase_next = phase_q + PHASE_W'(1);
    end else if (framed) begin
      phase_next = '0;
      if (cnt_q < CNT_W'(LOCK_FRAMES)) cnt_n = cnt_q + CNT_W'(1);
      if (cnt_q >= CNT_W'(LOCK_FRAMES - 1)) lock_next = 1'b1;
    end else begin
      // slip: stay on the last position so the next bit is tried as a frame end
      cnt_n     = '0;
      lock_next = 1'b0;
    end
  end

  assign accept = clk_present && eval && framed && lock_next;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      cnt_q   <= '0;
      locked  <= 1'b0;
    end else begin
      phase_q <= phase_next;
      cnt_q   <= cnt_n;
      locked  <= lock_next;
    end
  end

  p_lock_on_frame_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(eval && framed && clk_present));

  p_drop_on_bad_frame_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && eval && !framed && clk_present) |=> !locked);

  p_absent_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_present |=> (!locked && phase_q == '0));

  p_wrap_on_frame_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (eval && framed && clk_present) |=> (phase_q == '0));
endmodule

// File: rtl/srp_out_stage.sv
module srp_out_stage
  import srp_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clk_present,
  input  logic               load,
  input  word_t              new_word,
  input  logic               lock_next,
  input  logic [PHASE_W-1:0] phase_next,
  output logic               pclk,
  output word_t              word
);
  word_t word_q;
  logic  pclk_q;
  logic  pclk_n;

  assign pclk_n = lock_next && (phase_next < PHASE_W'(HALF));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= idle_word();
      pclk_q <= 1'b0;
    end else begin
      pclk_q <= pclk_n;
      if (!clk_present) word_q <= idle_word();
      else if (load)    word_q <= new_word;
    end
  end

  assign pclk = clk_present && pclk_q;
  assign word = clk_present ? word_q : idle_word();

  p_hold_without_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_present && !load) |=> (word_q == $past(word_q)));

  p_change_at_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_present && $past(clk_present) && word_q != $past(word_q)) |-> (pclk_q && !$past(pclk_q)));
endmodule

// File: rtl/srp_deser.sv
module srp_deser
  import srp_pkg::*;
#(
  parameter int LOCK_FRAMES = 3
) (
  input  logic             bit_clk,
  input  logic             rst_n,
  input  logic             clk_present,
  input  logic             sdata_in,
  output logic             pclk_out,
  output logic [PIX_W-1:0] pix_out,
  output logic [CTL_W-1:0] ctl_out,
  output logic             lock_out
);
  frame_t             window;
  logic               framed;
  logic               par_good;
  word_t              rx_word;
  word_t              out_word;
  logic               eval;
  logic               accept;
  logic               locked;
  logic               lock_next;
  logic [PHASE_W-1:0] phase_next;
  logic               load;

  srp_shift_in u_shift (
    .clk    (bit_clk),
    .rst_n  (rst_n),
    .clear  (!clk_present),
    .sdata  (sdata_in),
    .window (window)
  );

  srp_frame_check u_check (
    .window   (window),
    .framed   (framed),
    .par_good (par_good),
    .word     (rx_word)
  );

  srp_aligner #(.LOCK_FRAMES(LOCK_FRAMES)) u_align (
    .clk         (bit_clk),
    .rst_n       (rst_n),
    .clk_present (clk_present),
    .framed      (framed),
    .eval        (eval),
    .accept      (accept),
    .locked      (locked),
    .lock_next   (lock_next),
    .phase_next  (phase_next)
  );

  assign load = accept && par_good;

  srp_out_stage u_out (
    .clk         (bit_clk),
    .rst_n       (rst_n),
    .clk_present (clk_present),
    .load        (load),
    .new_word    (rx_word),
    .lock_next   (lock_next),
    .phase_next  (phase_next),
    .pclk        (pclk_out),
    .word        (out_word)
  );

  assign pix_out  = out_word.pix;
  assign ctl_out  = out_word.ctl;
  assign lock_out = clk_present && locked;

  p_bad_parity_no_load_r4: assert property (@(posedge bit_clk) disable iff (!rst_n)
    (accept && !par_good) |-> !load);

  p_idle_outputs_r6: assert property (@(posedge bit_clk) disable iff (!rst_n)
    !clk_present |-> (!pclk_out && !ctl_out[DE_IDX] && (&pix_out)));
endmodule

// File: tb/srp_deser_test.sv
module srp_deser_test;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n, clk_present, sdata;
  logic        pclk_out, lock_out;
  logic [23:0] pix_out;
  logic [2:0]  ctl_out;

  srp_deser uut (
    .bit_clk(clk), .rst_n(rst_n), .clk_present(clk_present), .sdata_in(sdata),
    .pclk_out(pclk_out), .pix_out(pix_out), .ctl_out(ctl_out), .lock_out(lock_out)
  );

  localparam logic [26:0] IDLE = {3'b110, 24'hFFFFFF};
  int checks = 0;
  int fails  = 0;
  logic [26:0] exp_word;

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [29:0] mk_frame(logic [26:0] pay, bit bad_par, bit no_start);
    logic [29:0] f;
    f[0] = !no_start;
    for (int i = 0; i < 27; i++) f[i+1] = pay[i];
    f[28] = (^pay) ^ bad_par;
    f[29] = 1'b0;
    return f;
  endfunction

  task automatic send_frame(logic [29:0] f, bit probe);
    int bad = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (probe) begin
        if (pclk_out !== (i < 15)) bad++;
        if ({ctl_out, pix_out} !== exp_word) bad++;
      end
      sdata = f[i];
    end
    if (probe) chk(bad == 0, "R5 pclk/stability", 32'(bad), 0);
  endtask

  task automatic after_frame();
    @(posedge clk);
    #1;
  endtask

  task automatic send_zeros(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      sdata = 1'b0;
    end
  endtask

  task automatic relock(int k);
    send_zeros(k);
    for (int n = 0; n < 3; n++) begin
      send_frame(mk_frame(27'd0, 1'b0, 1'b0), 1'b0);
      after_frame();
      if (n < 2) chk(lock_out == 1'b0, "R2 early lock", 32'(lock_out), 0);
    end
    chk(lock_out == 1'b1, "R3 lock at offset", 32'(lock_out), 1);
    chk(pclk_out == 1'b1, "R5 pclk rise", 32'(pclk_out), 1);
    chk({ctl_out, pix_out} == 27'd0, "R2 first word", 32'({ctl_out, pix_out}), 0);
    exp_word = 27'd0;
  endtask

  task automatic random_frames(int n);
    for (int j = 0; j < n; j++) begin
      logic [26:0] pay;
      bit bad;
      pay = 27'($urandom());
      bad = ($urandom() % 6) == 0;
      send_frame(mk_frame(pay, bad, 1'b0), 1'b1);
      after_frame();
      if (!bad) exp_word = pay;
      chk({ctl_out, pix_out} == exp_word, bad ? "R4 parity hold" : "R1 word map",
          32'({ctl_out, pix_out}), 32'(exp_word));
      chk(lock_out && pclk_out, "R4 lock kept/R5", 32'({lock_out, pclk_out}), 3);
    end
  endtask

  initial begin
    #(20 * 200000);
    checks++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; clk_present = 1'b1; sdata = 1'b0;
    exp_word = IDLE;
    repeat (3) @(negedge clk);
    #1;
    // R8: reset state
    chk(pclk_out == 1'b0, "R8 pclk", 32'(pclk_out), 0);
    chk(lock_out == 1'b0, "R8 lock", 32'(lock_out), 0);
    chk({ctl_out, pix_out} == IDLE, "R8 idle word", 32'({ctl_out, pix_out}), 32'(IDLE));
    @(negedge clk);
    rst_n = 1'b1;

    relock(int'($urandom() % 30));
    random_frames(24);

    // directed: data enable only, then colours with enable low
    exp_word = exp_word;
    send_frame(mk_frame({3'b001, 24'h000000}, 1'b0, 1'b0), 1'b1);
    after_frame();
    exp_word = {3'b001, 24'h000000};
    chk(ctl_out[0] == 1'b1 && pix_out == 24'h0, "R1 de bit", 32'({ctl_out, pix_out}), 32'(exp_word));
    send_frame(mk_frame({3'b110, 24'hA5C3F0}, 1'b0, 1'b0), 1'b1);
    after_frame();
    exp_word = {3'b110, 24'hA5C3F0};
    chk({ctl_out, pix_out} == exp_word, "R1 ctl order", 32'({ctl_out, pix_out}), 32'(exp_word));

    // R9: framing failure while locked
    send_frame(mk_frame(27'd0, 1'b0, 1'b1), 1'b1);
    after_frame();
    chk(lock_out == 1'b0, "R9 lock drop", 32'(lock_out), 0);
    chk(pclk_out == 1'b0, "R9 pclk low", 32'(pclk_out), 0);
    chk({ctl_out, pix_out} == exp_word, "R9 hold word", 32'({ctl_out, pix_out}), 32'(exp_word));
    relock(0);
    random_frames(8);

    // R6: clock loss
    @(negedge clk);
    clk_present = 1'b0;
    #1;
    chk(pclk_out == 1'b0 && lock_out == 1'b0, "R6 idle pclk/lock", 32'({pclk_out, lock_out}), 0);
    chk({ctl_out, pix_out} == IDLE, "R6 idle word", 32'({ctl_out, pix_out}), 32'(IDLE));
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      sdata = 1'($urandom());
    end
    #1;
    chk({ctl_out, pix_out} == IDLE && !pclk_out, "R6 idle static", 32'({ctl_out, pix_out}), 32'(IDLE));

    // R7: clock returns
    @(negedge clk);
    clk_present = 1'b1;
    sdata = 1'b0;
    #1;
    chk({ctl_out, pix_out} == IDLE && !lock_out, "R7 idle after return", 32'({ctl_out, pix_out}), 32'(IDLE));
    send_zeros(5);
    #1;
    chk({ctl_out, pix_out} == IDLE && !lock_out, "R7 still idle", 32'({ctl_out, pix_out}), 32'(IDLE));
    relock(int'($urandom() % 30));
    random_frames(12);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule